// File: doc/BRIEF.md
# Operand Stack Execution Unit

This unit executes the stack-manipulating and integer-arithmetic operations of a 32-bit stack machine. The operand stack sits in a small word-wide stack memory, addressed through a byte stack pointer that always moves by four. A dedicated top register always holds a copy of the element the pointer addresses. The fetch unit hands over one opcode at a time with a valid strobe. Every operation completes in a single cycle, and the unit acknowledges it with a completion pulse one cycle later.

The unit pushes constants, pops, duplicates, swaps and duplicates-with-insert. It applies add, subtract, multiply, divide, AND and OR to the two upper elements, and it moves single integers to and from a console port. Arithmetic faults set a sticky halt flag. The unit also exports the zero and sign flags of the top value and an equality flag for the top two elements, which the branch logic uses.

Top module: `stk_unit`

## Requirements
- R1: After reset, sp is 0xFFFFFFFC (an empty stack), tos is 0, halt is 0 and done is 0.
- R2: An accepted opcode (op_valid high while halt is low) produces done high in the next cycle. Opcode 0x03 pushes 0, 0x02 pushes -1, 0x04 pushes 1 and 0xFE pushes con_in. A push raises sp by 4 and loads the pushed value into tos.
- R3: Opcode 0x57 lowers sp by 4 and loads tos with the element that becomes the top. Whenever sp is non-negative, tos equals the memory word at sp.
- R4: Opcode 0x59 pushes a copy of the top element. Opcode 0x5F exchanges the top two elements and leaves sp unchanged.
- R5: Opcode 0x5A turns (.. a b) into (.. b a b). Opcode 0x5B turns (.. a b c) into (.. c a b c). Both raise sp by 4.
- R6: The binary opcodes are 0x60 add, 0x64 subtract, 0x68 multiply, 0x6C divide, 0x7E AND and 0x80 OR. Each uses the second element as the left operand and the top element as the right operand. The result replaces both elements, sp drops by 4 and tos takes the result. Division truncates toward zero.
- R7: Each of the following sets halt and leaves sp, tos and the stack contents unchanged: signed overflow on add, subtract or multiply, a zero divisor, and the most negative value divided by -1.
- R8: halt stays set until reset. While it is set, opcodes are not accepted, done stays low and sp does not change.
- R9: Opcode 0xFF places the top element on con_out with con_out_valid high for one cycle, alongside done, and lowers sp by 4. tos is reloaded from the new top only if the new sp is non-negative. Otherwise tos keeps its value.
- R10: tos_zero is high exactly when tos is 0. tos_neg equals bit 31 of tos. top2_eq is high when the top two elements are equal.
- R11: Any other opcode is accepted with a done pulse and changes neither sp nor tos.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Opcode strobe from fetch |
| opcode | input | 8 | Operation code |
| con_in | input | 32 | Console input integer |
| done | output | 1 | Completion pulse, one cycle after acceptance |
| con_out | output | 32 | Console output integer |
| con_out_valid | output | 1 | con_out carries a new value |
| halt | output | 1 | Sticky arithmetic fault |
| sp | output | 32 | Byte stack pointer |
| tos | output | 32 | Cached top element |
| tos_zero | output | 1 | tos equals zero |
| tos_neg | output | 1 | tos is negative |
| top2_eq | output | 1 | Top two elements are equal |

## Verification
The binary operations are swept over every ordered pair drawn from a set of ten operands. The set contains 0, ±1, the two extreme values and ordinary small numbers of both signs. This separates a swapped operand order, a wrong truncation direction and a missed or spurious overflow at each saturation edge. After each faulting pair an extra opcode is issued to show that the halt is sticky. A directed sequence of pushes, duplicates, swaps and inserts is then drained through the console. This exposes any misplaced slot in the memory, any step of the cached top that is out of date, and the rule that the top register is left alone when the stack empties.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam logic [7:0] OPC_PUSH_M1 = 8'h02;
  localparam logic [7:0] OPC_PUSH_0  = 8'h03;
  localparam logic [7:0] OPC_PUSH_1  = 8'h04;
  localparam logic [7:0] OPC_POP     = 8'h57;
  localparam logic [7:0] OPC_DUP     = 8'h59;
  localparam logic [7:0] OPC_DUPX1   = 8'h5A;
  localparam logic [7:0] OPC_DUPX2   = 8'h5B;
  localparam logic [7:0] OPC_SWAP    = 8'h5F;
  localparam logic [7:0] OPC_ADD     = 8'h60;
  localparam logic [7:0] OPC_SUB     = 8'h64;
  localparam logic [7:0] OPC_MUL     = 8'h68;
  localparam logic [7:0] OPC_DIV     = 8'h6C;
  localparam logic [7:0] OPC_AND     = 8'h7E;
  localparam logic [7:0] OPC_OR      = 8'h80;
  localparam logic [7:0] OPC_IN      = 8'hFE;
  localparam logic [7:0] OPC_OUT     = 8'hFF;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_MUL, ALU_DIV, ALU_AND, ALU_OR
  } alu_op_e;

  // slot positions relative to sp, in words
  localparam int SLOT_M2 = 0;
  localparam int SLOT_M1 = 1;
  localparam int SLOT_0  = 2;
  localparam int SLOT_P1 = 3;
endpackage

// File: rtl/stk_mem.sv
module stk_mem #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int NRD    = 3,
  parameter int NWR    = 4
) (
  input  logic                        clk,
  input  logic [NRD-1:0][IDX_W-1:0]   rd_idx,
  output logic [NRD-1:0][DATA_W-1:0]  rd_data,
  input  logic [NWR-1:0]              wr_en,
  input  logic [NWR-1:0][IDX_W-1:0]   wr_idx,
  input  logic [NWR-1:0][DATA_W-1:0]  wr_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // higher-numbered write ports take precedence on a shared index
  always_ff @(posedge clk) begin
    for (int p = 0; p < NWR; p++) begin
      if (wr_en[p]) mem_q[wr_idx[p]] <= wr_data[p];
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data[r] = mem_q[rd_idx[r]];
  end
endmodule

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e             op,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic [DATA_W-1:0]   res,
  output logic                fault
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic signed [2*DATA_W-1:0] prod;
  logic [DATA_W:0]            prod_hi;
  logic                       div_bad;
  logic [DATA_W-1:0]          den;
  logic signed [DATA_W-1:0]   quot;

  assign prod    = $signed({{DATA_W{lhs[DATA_W-1]}}, lhs}) *
                   $signed({{DATA_W{rhs[DATA_W-1]}}, rhs});
  assign prod_hi = prod[2*DATA_W-1:DATA_W-1];
  assign div_bad = (rhs == '0) || ((lhs == MOST_NEG) && (rhs == ALL_ONES));
  assign den     = div_bad ? {{(DATA_W-1){1'b0}}, 1'b1} : rhs;
  assign quot    = $signed(lhs) / $signed(den);

  always_comb begin
    res   = '0;
    fault = 1'b0;
    case (op)
      ALU_ADD: begin
        res   = lhs + rhs;
        fault = (lhs[DATA_W-1] == rhs[DATA_W-1]) && (res[DATA_W-1] != lhs[DATA_W-1]);
      end
      ALU_SUB: begin
        res   = lhs - rhs;
        fault = (lhs[DATA_W-1] != rhs[DATA_W-1]) && (res[DATA_W-1] != lhs[DATA_W-1]);
      end
      ALU_MUL: begin
        res   = prod[DATA_W-1:0];
        fault = (prod_hi != '0) && (prod_hi != '1);
      end
      ALU_DIV: begin
        res   = quot;
        fault = div_bad;
      end
      ALU_AND: res = lhs & rhs;
      ALU_OR:  res = lhs | rhs;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] con_in,
  output logic              done,
  output logic [DATA_W-1:0] con_out,
  output logic              con_out_valid,
  output logic              halt,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] tos,
  output logic              tos_zero,
  output logic              tos_neg,
  output logic              top2_eq
);
  localparam int WORDS = MEM_BYTES / 4;
  localparam int IDX_W = $clog2(WORDS);
  localparam int NRD   = 3;
  localparam int NWR   = 4;
  localparam logic [DATA_W-1:0] STEP  = DATA_W'(4);
  localparam logic [DATA_W-1:0] EMPTY = '0 - STEP;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [DATA_W-1:0] sp_q, sp_nx, tos_q, tos_nx, cout_q, cout_nx;
  logic              halt_q, halt_nx, done_q, done_nx, coutv_q, coutv_nx;

  // slot addressing around sp
  logic [NWR-1:0][DATA_W-1:0]  slot_addr;
  logic [NWR-1:0][IDX_W-1:0]   slot_idx;
  logic [NRD-1:0][DATA_W-1:0]  rd_data;
  logic [NWR-1:0]              wr_en;
  logic [NWR-1:0][DATA_W-1:0]  wr_data;

  for (genvar s = 0; s < NWR; s++) begin : g_slot
    assign slot_addr[s] = sp_q + DATA_W'(4 * (s - SLOT_0));
    assign slot_idx[s]  = slot_addr[s][IDX_W+1:2];
  end

  stk_mem #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NRD(NRD), .NWR(NWR)) u_mem (
    .clk     (clk),
    .rd_idx  (slot_idx[NRD-1:0]),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (slot_idx),
    .wr_data (wr_data)
  );

  logic [DATA_W-1:0] e_m2, e_m1, e_0;
  assign e_m2 = rd_data[SLOT_M2];
  assign e_m1 = rd_data[SLOT_M1];
  assign e_0  = rd_data[SLOT_0];

  // binary operation decode
  alu_op_e           alu_op;
  logic              is_bin;
  logic [DATA_W-1:0] alu_res;
  logic              alu_fault;

  always_comb begin
    is_bin = 1'b1;
    alu_op = ALU_ADD;
    case (opcode)
      OPC_ADD: alu_op = ALU_ADD;
      OPC_SUB: alu_op = ALU_SUB;
      OPC_MUL: alu_op = ALU_MUL;
      OPC_DIV: alu_op = ALU_DIV;
      OPC_AND: alu_op = ALU_AND;
      OPC_OR:  alu_op = ALU_OR;
      default: is_bin = 1'b0;
    endcase
  end

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (alu_op),
    .lhs   (e_m1),
    .rhs   (tos_q),
    .res   (alu_res),
    .fault (alu_fault)
  );

  logic fire;
  assign fire = op_valid && !halt_q;

  logic [DATA_W-1:0] sp_dn;
  assign sp_dn = sp_q - STEP;

  // next-state logic
  always_comb begin
    sp_nx    = sp_q;
    tos_nx   = tos_q;
    halt_nx  = halt_q;
    cout_nx  = cout_q;
    coutv_nx = 1'b0;
    done_nx  = 1'b0;
    wr_en    = '0;
    wr_data  = '0;
    if (fire) begin
      done_nx = 1'b1;
      if (is_bin) begin
        if (alu_fault) begin
          halt_nx = 1'b1;
        end else begin
          wr_en[SLOT_M1]   = 1'b1;
          wr_data[SLOT_M1] = alu_res;
          sp_nx            = sp_dn;
          tos_nx           = alu_res;
        end
      end else begin
        case (opcode)
          OPC_PUSH_M1, OPC_PUSH_0, OPC_PUSH_1, OPC_IN, OPC_DUP: begin
            case (opcode)
              OPC_PUSH_M1: tos_nx = '1;
              OPC_PUSH_0:  tos_nx = '0;
              OPC_PUSH_1:  tos_nx = DATA_W'(1);
              OPC_IN:      tos_nx = con_in;
              default:     tos_nx = tos_q;
            endcase
            wr_en[SLOT_P1]   = 1'b1;
            wr_data[SLOT_P1] = tos_nx;
            sp_nx            = sp_q + STEP;
          end
          OPC_POP: begin
            sp_nx  = sp_dn;
            tos_nx = e_m1;
          end
          OPC_SWAP: begin
            wr_en[SLOT_M1]   = 1'b1;
            wr_data[SLOT_M1] = tos_q;
            wr_en[SLOT_0]    = 1'b1;
            wr_data[SLOT_0]  = e_m1;
            tos_nx           = e_m1;
          end
          OPC_DUPX1: begin
            wr_en[SLOT_M1]   = 1'b1;
            wr_data[SLOT_M1] = tos_q;
            wr_en[SLOT_0]    = 1'b1;
            wr_data[SLOT_0]  = e_m1;
            wr_en[SLOT_P1]   = 1'b1;
            wr_data[SLOT_P1] = tos_q;
            sp_nx            = sp_q + STEP;
          end
          OPC_DUPX2: begin
            wr_en[SLOT_M2]   = 1'b1;
            wr_data[SLOT_M2] = tos_q;
            wr_en[SLOT_M1]   = 1'b1;
            wr_data[SLOT_M1] = e_m2;
            wr_en[SLOT_0]    = 1'b1;
            wr_data[SLOT_0]  = e_m1;
            wr_en[SLOT_P1]   = 1'b1;
            wr_data[SLOT_P1] = tos_q;
            sp_nx            = sp_q + STEP;
          end
          OPC_OUT: begin
            cout_nx  = tos_q;
            coutv_nx = 1'b1;
            sp_nx    = sp_dn;
            if (!sp_dn[DATA_W-1]) tos_nx = e_m1;
          end
          default: ;
        endcase
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sp_q    <= EMPTY;
      tos_q   <= '0;
      halt_q  <= 1'b0;
      done_q  <= 1'b0;
      cout_q  <= '0;
      coutv_q <= 1'b0;
    end else begin
      sp_q    <= sp_nx;
      tos_q   <= tos_nx;
      halt_q  <= halt_nx;
      done_q  <= done_nx;
      cout_q  <= cout_nx;
      coutv_q <= coutv_nx;
    end
  end

  assign sp            = sp_q;
  assign tos           = tos_q;
  assign halt          = halt_q;
  assign done          = done_q;
  assign con_out       = cout_q;
  assign con_out_valid = coutv_q;
  assign tos_zero      = (tos_q == '0);
  assign tos_neg       = tos_q[DATA_W-1];
  assign top2_eq       = (tos_q == e_m1);

  // checks next to the logic they guard
  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> $past(op_valid) && !$past(halt_q));

  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    fire |=> (sp_q == $past(sp_q)) || (sp_q == $past(sp_q) + STEP) ||
             (sp_q == $past(sp_q) - STEP));

  assert_tos_mirror_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sp_q[DATA_W-1] |-> (tos_q == e_0));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    halt_q |=> halt_q);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    halt_q |=> !done_q && $stable(sp_q));

  assert_fault_no_commit_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(halt_q) |-> $stable(sp_q) && $stable(tos_q));

  assert_out_with_done_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    con_out_valid |-> done);
endmodule

// File: tb/stk_unit_tb.sv
module stk_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [31:0] con_in = '0;
  logic        done, con_out_valid, halt, tos_zero, tos_neg, top2_eq;
  logic [31:0] con_out, sp, tos;

  always #5 clk = ~clk;

  stk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .con_in(con_in), .done(done), .con_out(con_out),
    .con_out_valid(con_out_valid), .halt(halt), .sp(sp), .tos(tos),
    .tos_zero(tos_zero), .tos_neg(tos_neg), .top2_eq(top2_eq)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // reference model
  int m_stk[$];
  int m_tos;
  bit m_halt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    op_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_stk.delete();
    m_tos = 0;
    m_halt = 1'b0;
  endtask

  function automatic bit is_bin(input logic [7:0] o);
    return o inside {8'h60, 8'h64, 8'h68, 8'h6C, 8'h7E, 8'h80};
  endfunction

  task automatic issue(input logic [7:0] o, input int cin, input string req);
    int a, b, c, r, out_exp;
    bit flt, exp_outv, exp_done;
    longint wide;
    exp_outv = 1'b0;
    out_exp = 0;
    flt = 1'b0;
    r = 0;
    exp_done = !m_halt;
    @(negedge clk);
    op_valid = 1'b1;
    opcode = o;
    con_in = cin;
    @(negedge clk);
    op_valid = 1'b0;
    if (!m_halt) begin
      if (is_bin(o)) begin
        b = m_stk.pop_back();
        a = m_stk.pop_back();
        case (o)
          8'h60: begin wide = longint'(a) + longint'(b); r = a + b;
                   flt = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
          8'h64: begin wide = longint'(a) - longint'(b); r = a - b;
                   flt = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
          8'h68: begin wide = longint'(a) * longint'(b); r = a * b;
                   flt = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
          8'h6C: begin flt = (b == 0) || (a == 32'h80000000 && b == -1);
                   r = flt ? 0 : a / b; end
          8'h7E: r = a & b;
          default: r = a | b;
        endcase
        if (flt) begin
          m_halt = 1'b1;
          m_stk.push_back(a);
          m_stk.push_back(b);
        end else begin
          m_stk.push_back(r);
          m_tos = r;
        end
      end else begin
        case (o)
          8'h02: begin m_tos = -1; m_stk.push_back(m_tos); end
          8'h03: begin m_tos = 0;  m_stk.push_back(m_tos); end
          8'h04: begin m_tos = 1;  m_stk.push_back(m_tos); end
          8'hFE: begin m_tos = cin; m_stk.push_back(m_tos); end
          8'h59: m_stk.push_back(m_tos);
          8'h57: begin void'(m_stk.pop_back()); m_tos = m_stk[$]; end
          8'h5F: begin b = m_stk.pop_back(); a = m_stk.pop_back();
                   m_stk.push_back(b); m_stk.push_back(a); m_tos = a; end
          8'h5A: begin b = m_stk.pop_back(); a = m_stk.pop_back();
                   m_stk.push_back(b); m_stk.push_back(a); m_stk.push_back(b); end
          8'h5B: begin c = m_stk.pop_back(); b = m_stk.pop_back(); a = m_stk.pop_back();
                   m_stk.push_back(c); m_stk.push_back(a); m_stk.push_back(b);
                   m_stk.push_back(c); end
          8'hFF: begin out_exp = m_stk.pop_back(); exp_outv = 1'b1;
                   if (m_stk.size() > 0) m_tos = m_stk[$]; end
          default: ;
        endcase
      end
    end
    chk(done == exp_done, req, "done", done, exp_done);
    chk(sp == 32'(4 * m_stk.size() - 4), req, "sp", sp, 32'(4 * m_stk.size() - 4));
    chk(tos == m_tos, req, "tos", tos, m_tos);
    chk(halt == m_halt, (flt || m_halt) ? "R7" : req, "halt", halt, m_halt);
    chk(con_out_valid == exp_outv, "R9", "con_out_valid", con_out_valid, exp_outv);
    if (exp_outv) chk(con_out == out_exp, "R9", "con_out", con_out, out_exp);
    chk(tos_zero == (m_tos == 0), "R10", "tos_zero", tos_zero, m_tos == 0);
    chk(tos_neg == (m_tos < 0), "R10", "tos_neg", tos_neg, m_tos < 0);
    if (m_stk.size() >= 2)
      chk(top2_eq == (m_stk[$] == m_stk[$-1]), "R10", "top2_eq", top2_eq,
          m_stk[$] == m_stk[$-1]);
  endtask

  task automatic drain(input string req);
    while (m_stk.size() > 0) issue(8'hFF, 0, req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  int vals[10] = '{0, 1, -1, 7, -3, 100, -100, 46341,
                   32'h7FFFFFFF, 32'h80000000};
  logic [7:0] bops[6] = '{8'h60, 8'h64, 8'h68, 8'h6C, 8'h7E, 8'h80};

  initial begin
    do_reset();
    // R1 reset state
    chk(sp == 32'hFFFFFFFC, "R1", "sp", sp, 32'hFFFFFFFC);
    chk(tos == 0, "R1", "tos", tos, 0);
    chk(halt == 1'b0, "R1", "halt", halt, 0);
    chk(done == 1'b0, "R1", "done", done, 0);

    // R2 pushes
    issue(8'h03, 0, "R2");
    issue(8'h02, 0, "R2");
    issue(8'h04, 0, "R2");
    issue(8'hFE, 32'h1234_5678, "R2");
    issue(8'hFE, -9, "R2");
    // R4 dup and swap
    issue(8'h59, 0, "R4");
    issue(8'h5F, 0, "R4");
    issue(8'hFE, 55, "R4");
    issue(8'h5F, 0, "R4");
    // R3 pop exposing older elements
    issue(8'h57, 0, "R3");
    issue(8'h57, 0, "R3");
    // R5 inserts
    issue(8'hFE, 11, "R5");
    issue(8'hFE, 22, "R5");
    issue(8'h5A, 0, "R5");
    issue(8'hFE, 33, "R5");
    issue(8'h5B, 0, "R5");
    // R11 unlisted opcodes
    issue(8'h00, 0, "R11");
    issue(8'h13, 0, "R11");
    issue(8'hA7, 0, "R11");
    // R9 drain with final tos retained
    drain("R9");
    issue(8'h04, 0, "R9");
    issue(8'hFE, 77, "R9");
    drain("R9");

    // R6/R7/R8 sweep of binary operations
    foreach (bops[k]) begin
      foreach (vals[i]) begin
        foreach (vals[j]) begin
          do_reset();
          issue(8'hFE, vals[i], "R6");
          issue(8'hFE, vals[j], "R6");
          issue(bops[k], 0, "R6");
          if (m_halt) begin
            issue(8'h04, 0, "R8");
          end else begin
            issue(8'hFF, 0, "R6");
          end
        end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule